// File: doc/BRIEF.md
# Beam Survivor Traceback with Convergence Hint

This block sits behind the pruning stage of a tree-search (beam) decoder. For every surviving candidate of a beam it stores the index of the candidate's parent in the previous beam and the small chunk of message bits that the candidate adds. Candidates arrive one per valid cycle, and their slot index is their arrival position within the beam. When a beam is complete, the block picks the candidate with the lowest path metric and walks parent links back toward older beams. Once enough beams are stored, it releases the chunk that lies a fixed distance behind the newest beam on that walk.

The walk of the previous beam is kept as a memo: one slot index per stored depth. The new walk stops as soon as it lands on a slot recorded in the memo, because from there on the two walks share ancestors. The number of steps to that merge point is reported with every beam. It serves as a confidence hint: short merges mean a stable survivor path, and long ones mean the search is struggling. A flag rises when the distance stays above a threshold for a set number of beams in a row. At the end of a packet, the chunks not yet released are read straight out of the memo, oldest first.

Top module: `beam_traceback`

## Requirements
- R1: A beam is BEAM consecutive candidates with `cand_valid` high. The n-th candidate of a beam (counting from 0) is slot n. Its `cand_parent` names a slot of the previous beam, and its `cand_bits` is the chunk added at this depth. The parent field of the first beam in a packet is never used.
- R2: The start of each walk is the slot with the smallest `cand_metric` in the beam. When several slots share that metric, the lowest slot wins.
- R3: After beam n of a packet (counting from 0), with n >= DEPTH-1, `bits_valid` pulses in the same cycle as `trace_done`. `bits_out` then carries the chunk of depth n-DEPTH+1 on the parent path from the best slot of beam n. Earlier beams release no bits.
- R4: For beam n, let the walk visit depths n-1, n-2, ... down to depth n-min(n,DEPTH-1). `conv_len` is 1 plus the number of steps taken before the walk first reaches a slot equal to the previous beam's path at that depth. It is DEPTH when no such match exists, which always holds for the first beam of a packet.
- R5: Count clock edges from the edge that captures a beam's last candidate. The `trace_done` pulse is visible after edge `conv_len` when a merge occurred. Otherwise it is visible after edge min(n,DEPTH-1)+1.
- R6: A new beam may begin in the cycle right after the last candidate of the previous beam. The walk of the previous beam still returns the correct chunk and distance.
- R7: A `pkt_end` pulse may arrive while a walk is still running. Once the walk is finished, every chunk of the packet that has not yet been released is emitted on `bits_valid`, one per cycle, in depth order. `flush_done` then pulses, and the next beam begins a new packet.
- R8: `hint_hot` is high in the cycle after a `trace_done` exactly when `streak_len` is nonzero and the last `streak_len` or more distances were all greater than `conv_thresh`. It is low in the cycle after `flush_done`.
- R9: While `rst_n` is low, `trace_done`, `bits_valid`, `flush_done` and `hint_hot` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | One candidate of the current beam is present |
| cand_metric | input | MW | Path metric of the candidate, lower is better |
| cand_parent | input | log2(BEAM) | Slot of the parent in the previous beam |
| cand_bits | input | K | Message chunk added by the candidate |
| pkt_end | input | 1 | Pulse: packet over, release remaining chunks |
| conv_thresh | input | log2(DEPTH+1) | Distance above which a beam counts as weak |
| streak_len | input | RUNW | Number of weak beams in a row that raises the hint, 0 disables it |
| trace_done | output | 1 | Pulse: walk of the latest beam finished |
| conv_len | output | log2(DEPTH+1) | Merge distance of the latest walk |
| bits_valid | output | 1 | Pulse: `bits_out` carries a released chunk |
| bits_out | output | K | Released message chunk |
| hint_hot | output | 1 | Weak-decode hint |
| flush_done | output | 1 | Pulse: end-of-packet release finished |

## Verification
Two things can happen in the same cycle. The storage can write the first slots of a new beam while the walk of the previous beam is still reading its oldest stored row. Separately, the end-of-packet request can land while that walk is still running. Both are provoked by sending beams with no idle cycle between them and by pulsing `pkt_end` in the cycle right after the last candidate. A reference model computes the full parent paths from its own copy of the stimulus. Every released chunk is checked against it in order, and each walk's distance and latency are checked as well. A lost or overwritten row shows up as a wrong chunk or a wrong distance, and a lost request shows up as missing chunks or a missing `flush_done`.

// File: rtl/btrace_pkg.sv
package btrace_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CHASE = 2'd1,
      ST_FLUSH = 2'd2
   } walk_state_e;
endpackage

// File: rtl/btrace_best.sv
module btrace_best #(
   parameter int BEAM = 16,
   parameter int MW   = 12,
   localparam int SW  = $clog2(BEAM)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [MW-1:0] in_metric,
   output logic [SW-1:0] slot,
   output logic          beam_done,
   output logic [SW-1:0] fin_slot
);
   logic [MW-1:0] best_m;
   logic [SW-1:0] best_s;
   logic          take_new;

   assign take_new  = (slot == '0) || (in_metric < best_m);
   assign fin_slot  = take_new ? slot : best_s;
   assign beam_done = in_valid && (slot == SW'(BEAM-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot   <= '0;
         best_m <= '0;
         best_s <= '0;
      end else if (in_valid) begin
         slot <= (slot == SW'(BEAM-1)) ? '0 : slot + SW'(1);
         if (take_new) begin
            best_m <= in_metric;
            best_s <= slot;
         end
      end
   end
endmodule

// File: rtl/btrace_store.sv
module btrace_store #(
   parameter int BEAM = 16,
   parameter int ROWS = 9,
   parameter int K    = 4,
   localparam int SW  = $clog2(BEAM),
   localparam int RW  = $clog2(ROWS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [RW-1:0] wrow,
   input  logic [SW-1:0] wslot,
   input  logic [SW-1:0] wpar,
   input  logic [K-1:0]  wdat,
   input  logic [RW-1:0] rrow_a,
   input  logic [SW-1:0] rslot_a,
   output logic [SW-1:0] par_a,
   input  logic [RW-1:0] rrow_b,
   input  logic [SW-1:0] rslot_b,
   output logic [K-1:0]  dat_b
);
   logic [SW-1:0] par_m [ROWS][BEAM];
   logic [K-1:0]  dat_m [ROWS][BEAM];

   always_ff @(posedge clk) begin
      if (we) begin
         par_m[wrow][wslot] <= wpar;
         dat_m[wrow][wslot] <= wdat;
      end
   end

   assign par_a = par_m[rrow_a][rslot_a];
   assign dat_b = dat_m[rrow_b][rslot_b];
endmodule

// File: rtl/btrace_chase.sv
module btrace_chase
   import btrace_pkg::*;
#(
   parameter int BEAM  = 16,
   parameter int DEPTH = 8,
   parameter int K     = 4,
   localparam int ROWS = DEPTH + 1,
   localparam int SW   = $clog2(BEAM),
   localparam int RW   = $clog2(ROWS),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          beam_done,
   input  logic [SW-1:0] best_slot,
   input  logic          pkt_end,
   output logic [RW-1:0] wr_row,
   output logic [RW-1:0] rd_row_a,
   output logic [SW-1:0] rd_slot_a,
   input  logic [SW-1:0] par_rd,
   output logic [RW-1:0] rd_row_b,
   output logic [SW-1:0] rd_slot_b,
   input  logic [K-1:0]  dat_rd,
   output logic          trace_done,
   output logic [CW-1:0] conv_len,
   output logic          bits_valid,
   output logic [K-1:0]  bits_out,
   output logic          flush_done
);
   walk_state_e   state;
   logic [SW-1:0] memo [ROWS];
   logic [SW-1:0] cur;
   logic [RW-1:0] crow, lorow, fl_row, prow;
   logic [CW-1:0] fill, st, span_r, fl_cnt;
   logic          flush_pend, meet, at_end, go_flush, full_span;
   logic          memo_we;
   logic [RW-1:0] memo_idx;
   logic [SW-1:0] memo_val;

   function automatic logic [RW-1:0] row_inc(input logic [RW-1:0] r);
      return (r == RW'(ROWS-1)) ? '0 : r + RW'(1);
   endfunction

   assign prow      = (crow == '0) ? RW'(ROWS-1) : crow - RW'(1);
   assign at_end    = (state == ST_CHASE) && (st == span_r);
   assign meet      = (state == ST_CHASE) && !at_end && (par_rd == memo[prow]);
   assign go_flush  = (state == ST_IDLE) && !beam_done && flush_pend;
   assign full_span = (span_r == CW'(DEPTH-1));

   assign rd_row_a  = crow;
   assign rd_slot_a = cur;
   assign rd_row_b  = (state == ST_FLUSH) ? fl_row : lorow;
   assign rd_slot_b = (state == ST_FLUSH) ? memo[fl_row] :
                      (meet ? memo[lorow] : cur);

   always_comb begin
      memo_we  = 1'b0;
      memo_idx = wr_row;
      memo_val = best_slot;
      if (state == ST_IDLE && beam_done) begin
         memo_we = 1'b1;
      end else if (state == ST_CHASE && !at_end && !meet) begin
         memo_we  = 1'b1;
         memo_idx = prow;
         memo_val = par_rd;
      end
   end

   always_ff @(posedge clk) begin
      if (memo_we) memo[memo_idx] <= memo_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         wr_row     <= '0;
         fill       <= '0;
         cur        <= '0;
         crow       <= '0;
         st         <= '0;
         span_r     <= '0;
         lorow      <= '0;
         fl_row     <= '0;
         fl_cnt     <= '0;
         flush_pend <= 1'b0;
         trace_done <= 1'b0;
         conv_len   <= '0;
         bits_valid <= 1'b0;
         bits_out   <= '0;
         flush_done <= 1'b0;
      end else begin
         trace_done <= 1'b0;
         bits_valid <= 1'b0;
         flush_done <= 1'b0;
         if (pkt_end)       flush_pend <= 1'b1;
         else if (go_flush) flush_pend <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (beam_done) begin
                  state  <= ST_CHASE;
                  cur    <= best_slot;
                  crow   <= wr_row;
                  st     <= '0;
                  span_r <= fill;
                  lorow  <= RW'((int'(wr_row) + ROWS - int'(fill)) % ROWS);
                  wr_row <= row_inc(wr_row);
                  if (fill != CW'(DEPTH-1)) fill <= fill + CW'(1);
               end else if (go_flush) begin
                  state <= ST_FLUSH;
               end
            end
            ST_CHASE: begin
               if (at_end || meet) begin
                  state      <= ST_IDLE;
                  trace_done <= 1'b1;
                  conv_len   <= meet ? st + CW'(1) : CW'(DEPTH);
                  bits_valid <= full_span;
                  bits_out   <= dat_rd;
                  fl_row     <= full_span ? row_inc(lorow) : lorow;
                  fl_cnt     <= full_span ? span_r : span_r + CW'(1);
               end else begin
                  cur  <= par_rd;
                  crow <= prow;
                  st   <= st + CW'(1);
               end
            end
            ST_FLUSH: begin
               if (fl_cnt == '0) begin
                  state      <= ST_IDLE;
                  fill       <= '0;
                  flush_done <= 1'b1;
               end else begin
                  bits_valid <= 1'b1;
                  bits_out   <= dat_rd;
                  fl_row     <= row_inc(fl_row);
                  fl_cnt     <= fl_cnt - CW'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/btrace_hint.sv
module btrace_hint #(
   parameter int DEPTH   = 8,
   parameter int RUNW    = 4,
   parameter bit HINT_EN = 1'b1,
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trace_done,
   input  logic [CW-1:0]   conv_len,
   input  logic [CW-1:0]   thresh,
   input  logic [RUNW-1:0] run_len,
   input  logic            clear,
   output logic            hint
);
   generate
      if (HINT_EN) begin : g_on
         logic [RUNW-1:0] streak;
         always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
               streak <= '0;
            end else if (trace_done) begin
               if (conv_len <= thresh)    streak <= '0;
               else if (streak != '1)     streak <= streak + RUNW'(1);
            end
         end
         assign hint = rst_n && (run_len != '0) && (streak >= run_len);
      end else begin : g_off
         assign hint = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/beam_traceback.sv
module beam_traceback #(
   parameter int BEAM    = 16,
   parameter int DEPTH   = 8,
   parameter int K       = 4,
   parameter int MW      = 12,
   parameter int RUNW    = 4,
   parameter bit HINT_EN = 1'b1,
   localparam int ROWS   = DEPTH + 1,
   localparam int SW     = $clog2(BEAM),
   localparam int RW     = $clog2(ROWS),
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cand_valid,
   input  logic [MW-1:0]   cand_metric,
   input  logic [SW-1:0]   cand_parent,
   input  logic [K-1:0]    cand_bits,
   input  logic            pkt_end,
   input  logic [CW-1:0]   conv_thresh,
   input  logic [RUNW-1:0] streak_len,
   output logic            trace_done,
   output logic [CW-1:0]   conv_len,
   output logic            bits_valid,
   output logic [K-1:0]    bits_out,
   output logic            hint_hot,
   output logic            flush_done
);
   generate
      if (BEAM <= DEPTH) begin : g_bad_beam
         $error("beam_traceback: BEAM must exceed DEPTH so a walk ends before the next beam");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("beam_traceback: DEPTH must be at least 2");
      end
   endgenerate

   logic [SW-1:0] slot, best_slot, par_rd, rd_slot_a, rd_slot_b;
   logic [RW-1:0] wr_row, rd_row_a, rd_row_b;
   logic [K-1:0]  dat_rd;
   logic          beam_done;

   btrace_best #(.BEAM(BEAM), .MW(MW)) u_best (
      .clk(clk), .rst_n(rst_n), .in_valid(cand_valid), .in_metric(cand_metric),
      .slot(slot), .beam_done(beam_done), .fin_slot(best_slot)
   );

   btrace_store #(.BEAM(BEAM), .ROWS(ROWS), .K(K)) u_store (
      .clk(clk), .we(cand_valid), .wrow(wr_row), .wslot(slot),
      .wpar(cand_parent), .wdat(cand_bits),
      .rrow_a(rd_row_a), .rslot_a(rd_slot_a), .par_a(par_rd),
      .rrow_b(rd_row_b), .rslot_b(rd_slot_b), .dat_b(dat_rd)
   );

   btrace_chase #(.BEAM(BEAM), .DEPTH(DEPTH), .K(K)) u_chase (
      .clk(clk), .rst_n(rst_n), .beam_done(beam_done), .best_slot(best_slot),
      .pkt_end(pkt_end), .wr_row(wr_row),
      .rd_row_a(rd_row_a), .rd_slot_a(rd_slot_a), .par_rd(par_rd),
      .rd_row_b(rd_row_b), .rd_slot_b(rd_slot_b), .dat_rd(dat_rd),
      .trace_done(trace_done), .conv_len(conv_len),
      .bits_valid(bits_valid), .bits_out(bits_out), .flush_done(flush_done)
   );

   btrace_hint #(.DEPTH(DEPTH), .RUNW(RUNW), .HINT_EN(HINT_EN)) u_hint (
      .clk(clk), .rst_n(rst_n), .trace_done(trace_done), .conv_len(conv_len),
      .thresh(conv_thresh), .run_len(streak_len), .clear(flush_done),
      .hint(hint_hot)
   );
endmodule

// File: rtl/beam_traceback_chk.sv
module beam_traceback_chk #(
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          trace_done,
   input logic [CW-1:0] conv_len,
   input logic          bits_valid,
   input logic          hint_hot,
   input logic          flush_done
);
   // R4
   conv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trace_done |-> (conv_len >= CW'(1) && conv_len <= CW'(DEPTH)));

   // R4
   conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trace_done |-> $stable(conv_len));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trace_done |=> !trace_done);

   // R7
   flush_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |-> (!trace_done && !bits_valid));

   // R8
   hint_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hint_hot) |-> $past(trace_done));

   // R8
   hint_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_done |=> !hint_hot);
endmodule

bind beam_traceback beam_traceback_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .trace_done(trace_done), .conv_len(conv_len),
   .bits_valid(bits_valid), .hint_hot(hint_hot), .flush_done(flush_done)
);

// File: tb/tb_beam_traceback.sv
module tb_beam_traceback;
   localparam int BEAM = 16;
   localparam int DEPTH = 8;
   localparam int K = 4;
   localparam int MW = 12;
   localparam int RUNW = 4;
   localparam int SW = $clog2(BEAM);
   localparam int CW = $clog2(DEPTH + 1);
   localparam int MAXB = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cand_valid = 1'b0;
   logic [MW-1:0] cand_metric = '0;
   logic [SW-1:0] cand_parent = '0;
   logic [K-1:0] cand_bits = '0;
   logic pkt_end = 1'b0;
   logic [CW-1:0] conv_thresh = '0;
   logic [RUNW-1:0] streak_len = '0;
   logic trace_done, bits_valid, hint_hot, flush_done;
   logic [CW-1:0] conv_len;
   logic [K-1:0] bits_out;

   beam_traceback #(.BEAM(BEAM), .DEPTH(DEPTH), .K(K), .MW(MW), .RUNW(RUNW)) dut (
      .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_metric(cand_metric),
      .cand_parent(cand_parent), .cand_bits(cand_bits), .pkt_end(pkt_end),
      .conv_thresh(conv_thresh), .streak_len(streak_len),
      .trace_done(trace_done), .conv_len(conv_len), .bits_valid(bits_valid),
      .bits_out(bits_out), .hint_hot(hint_hot), .flush_done(flush_done)
   );

   always #4 clk = ~clk;

   int nchk = 0;
   int nerr = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int par [MAXB][BEAM];
   int dat [MAXB][BEAM];
   int met [MAXB][BEAM];
   int best [MAXB];
   int c0 [MAXB];
   int got_conv [MAXB];
   int got_lat [MAXB];
   int got_hint [MAXB];
   int got_bits [MAXB];
   int nt = 0, nbits = 0;
   bit fd_seen = 0, td_prev = 0;
   int unsigned lcg = 32'd7;

   always @(negedge clk) begin
      if (rst_n) begin
         if (td_prev && nt > 0) got_hint[nt-1] = int'(hint_hot);
         td_prev = trace_done;
         if (trace_done && nt < MAXB) begin
            got_conv[nt] = int'(conv_len);
            got_lat[nt] = cyc;
            nt++;
         end
         if (bits_valid && nbits < MAXB) begin
            got_bits[nbits] = int'(bits_out);
            nbits++;
         end
         if (flush_done) fd_seen = 1;
      end
   end

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic int rnd();
      lcg = lcg * 32'd1103515245 + 32'd12345;
      return int'((lcg >> 16) & 32'h7fff);
   endfunction

   function automatic int path_at(input int n, input int j);
      int s = best[n];
      for (int d = n; d > j; d--) s = par[d][s];
      return s;
   endfunction

   task automatic gen(input int pat, input int nb);
      for (int d = 0; d < nb; d++) begin
         for (int s = 0; s < BEAM; s++) begin
            case (pat)
               0: begin par[d][s] = s; dat[d][s] = (s*3 + d) % 16;
                        met[d][s] = ((s + 160 - d*5) % 16) * 7 + 3; end
               1: begin par[d][s] = s; dat[d][s] = (s*3 + d) % 16;
                        met[d][s] = (s == 3) ? 1 : 100 + s; end
               2: begin par[d][s] = rnd() % BEAM; dat[d][s] = rnd() % 16;
                        met[d][s] = rnd() % 4096; end
               default: begin par[d][s] = rnd() % BEAM; dat[d][s] = rnd() % 16;
                        met[d][s] = 500; end
            endcase
         end
         best[d] = 0;
         for (int s = 1; s < BEAM; s++) if (met[d][s] < met[d][best[d]]) best[d] = s;
      end
   endtask

   // Shared driver and checker used by every packet scenario
   task automatic run_packet(input string tag, input int pat, input int nb, input int gap,
                             input int thr, input int runl);
      int t, span, conv, lat, streak, hexp, expb, j;
      nt = 0; nbits = 0; fd_seen = 0; td_prev = 0;
      conv_thresh = CW'(thr);
      streak_len = RUNW'(runl);
      gen(pat, nb);
      for (int d = 0; d < nb; d++) begin
         for (int s = 0; s < BEAM; s++) begin
            @(negedge clk);
            cand_valid = 1'b1;
            cand_metric = MW'(met[d][s]);
            cand_parent = SW'(par[d][s]);
            cand_bits = K'(dat[d][s]);
            if (s == BEAM-1) c0[d] = cyc;
         end
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            cand_valid = 1'b0;
         end
      end
      @(negedge clk);
      cand_valid = 1'b0;
      pkt_end = 1'b1;
      @(negedge clk);
      pkt_end = 1'b0;
      t = 0;
      while (!fd_seen && t < 300) begin
         @(negedge clk);
         t++;
      end
      repeat (2) @(negedge clk);
      chk(fd_seen, {tag, " R7 flush_done seen"}, int'(fd_seen), 1);
      chk(nt == nb, {tag, " R6 walk count"}, nt, nb);
      streak = 0;
      for (int n = 0; n < nb && n < nt; n++) begin
         span = (n < DEPTH-1) ? n : DEPTH-1;
         conv = DEPTH;
         for (int st = 0; st < span; st++) begin
            j = n - 1 - st;
            if (path_at(n, j) == path_at(n-1, j)) begin
               conv = st + 1;
               break;
            end
         end
         lat = (conv < DEPTH) ? conv : span + 1;
         chk(got_conv[n] == conv, $sformatf("%s R4 conv_len beam %0d", tag, n), got_conv[n], conv);
         chk(got_lat[n] - c0[n] - 1 == lat, $sformatf("%s R5 latency beam %0d", tag, n),
             got_lat[n] - c0[n] - 1, lat);
         if (conv > thr) streak = (streak < 15) ? streak + 1 : 15;
         else streak = 0;
         hexp = (runl != 0 && streak >= runl) ? 1 : 0;
         chk(got_hint[n] == hexp, $sformatf("%s R8 hint after beam %0d", tag, n), got_hint[n], hexp);
      end
      chk(nbits == nb, {tag, " R7 released chunk count"}, nbits, nb);
      for (int d = 0; d < nb && d < nbits; d++) begin
         if (d + DEPTH - 1 <= nb - 1) begin
            expb = dat[d][path_at(d + DEPTH - 1, d)];
            chk(got_bits[d] == expb, $sformatf("%s R3 chunk depth %0d", tag, d), got_bits[d], expb);
         end else begin
            expb = dat[d][path_at(nb - 1, d)];
            chk(got_bits[d] == expb, $sformatf("%s R7 flushed chunk depth %0d", tag, d), got_bits[d], expb);
         end
      end
      chk(hint_hot == 1'b0, {tag, " R8 hint low after flush"}, int'(hint_hot), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(trace_done == 1'b0, "R9 trace_done in reset", int'(trace_done), 0);
      chk(bits_valid == 1'b0, "R9 bits_valid in reset", int'(bits_valid), 0);
      chk(flush_done == 1'b0, "R9 flush_done in reset", int'(flush_done), 0);
      chk(hint_hot == 1'b0, "R9 hint_hot in reset", int'(hint_hot), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   // R6 R4 R8: separate lineages, best slot moves every beam, no merge, back-to-back beams
   task automatic t_diverging();
      run_packet("diverge", 0, 12, 0, 6, 3);
   endtask

   // R4 R5: one lineage always best, walk merges after a single step
   task automatic t_stable();
      run_packet("stable", 1, 10, 2, 6, 3);
   endtask

   // R1 R3: random parents and metrics, back-to-back
   task automatic t_random();
      run_packet("random R1", 2, 20, 0, 3, 2);
   endtask

   // R2: all metrics equal, the lowest slot must start every walk
   task automatic t_ties();
      run_packet("ties R2", 3, 9, 1, 8, 1);
   endtask

   // R7: packet shorter than the walk depth, everything comes out in the flush
   task automatic t_short();
      run_packet("short", 2, 3, 0, 3, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++;
      nchk++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      t_reset();
      t_diverging();
      t_stable();
      t_random();
      t_ties();
      t_short();
      t_random();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule